// File: doc/BRIEF.md
# Memory Dependence Wakeup Scoreboard

This block keeps a small table of the memory operations an out-of-order core has in flight: loads, stores, full barriers and write barriers. Each one is tagged with a sequence number and a thread. When an operation is inserted, the block decides whether it has to wait for an older store or barrier. The producer comes from an active barrier or, failing that, from a store-set style predictor whose answer arrives on `pred_seq`. A waiting operation records the table slot of its producer. When that store or barrier completes, every entry that names the slot is woken.

An entry is handed to the issue logic only once its source registers are ready and its memory dependence is resolved. Non-speculative entries wait instead for an explicit release command. Rescheduled operations are marked for replay, and a squash removes all younger entries of one thread. Released operations are presented one per cycle on a valid/ready output.

The block takes one command per cycle on a shared command port. Sequence numbers are assumed unique and increasing, with no wrap.

Top module: `mdep_scoreboard`

## Requirements
- R1: After a synchronous active-low reset the table is empty. `rdy_valid`, `tbl_full` and both fence flags are 0, and both conflict counters are 0.
- R2: `cmd_op` 1 inserts into the lowest-numbered free slot. `tbl_full` is 1 exactly when every slot holds an entry. An insert while full is dropped and leaves the table unchanged.
- R3: `cmd_kind` encodes 0 = load, 1 = store, 2 = full barrier, 3 = write barrier. Inserting a full barrier turns on both `ld_fence_on` and `st_fence_on` and records its sequence number for each. A write barrier turns on and records only the store fence.
- R4: A speculative load takes the load-fence sequence number as its producer while that fence is on. A speculative store takes the store-fence number while that fence is on. Otherwise the producer is `pred_seq`, where 0 means no producer.
- R5: If there is no producer, or no store or barrier with that sequence number is in the table, the new entry is memory-ready at once. If `cmd_regs_rdy` is also 1 at insert, the entry is released by that insert.
- R6: If the producer is present, the new entry waits on it. `conflict_loads` or `conflict_stores` then increments according to the new entry's kind.
- R7: An entry is released only when it is both register-ready and memory-ready. `cmd_op` 2 sets register-ready and releases the entry only if it is already memory-ready.
- R8: `cmd_op` 4 completes and removes an entry. Completing a store or barrier releases each waiting dependent that is register-ready and marks the others memory-ready. Completing a load wakes nothing.
- R9: Completing a full barrier clears each fence whose recorded number equals the barrier's number. Completing a write barrier clears the store fence only on a match. A fence recorded for a different number stays on.
- R10: `cmd_op` 7 removes every entry of thread `cmd_tid` whose sequence number is greater than `cmd_seq`, together with its pending release and replay mark. Later commands naming such an entry have no effect.
- R11: Barriers, and loads or stores inserted with `cmd_nonspec` = 1, skip the dependence check. They are released only by `cmd_op` 3, and never by `cmd_op` 2.
- R12: `cmd_op` 5 marks an entry for replay. `cmd_op` 6 releases every marked entry and clears all marks.
- R13: Released entries are presented lowest slot first on `rdy_seq`/`rdy_tid`. `rdy_valid` stays high while `rdy_ready` is low. An entry leaves the output only on a handshake, on its own completion, or when it is squashed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_op | input | 3 | Command: 0 none, 1 insert, 2 registers ready, 3 non-speculative release, 4 complete, 5 reschedule, 6 replay, 7 squash |
| cmd_seq | input | SEQ_W | Sequence number the command refers to |
| cmd_tid | input | TID_W | Thread of an insert or a squash |
| cmd_kind | input | 2 | Kind of an inserted operation |
| cmd_regs_rdy | input | 1 | Registers already ready at insert |
| cmd_nonspec | input | 1 | Insert as non-speculative |
| pred_seq | input | SEQ_W | Predicted producing store, 0 for none |
| tbl_full | output | 1 | Every slot occupied |
| rdy_valid | output | 1 | A released operation is presented |
| rdy_ready | input | 1 | Issue logic accepts the presented operation |
| rdy_seq | output | SEQ_W | Sequence number of the presented operation |
| rdy_tid | output | TID_W | Thread of the presented operation |
| ld_fence_on | output | 1 | Load fence active |
| st_fence_on | output | 1 | Store fence active |
| conflict_loads | output | CNT_W | Loads that were made to wait on a producer |
| conflict_stores | output | CNT_W | Stores that were made to wait on a producer |

## Verification
A lost producer link shows up as a dependent that never reaches `rdy_valid` after its store completes, or as one that reaches it early, in the cycle after the insert. A stale pending or replay bit left behind by a squash makes a removed sequence number appear on `rdy_seq`. A fence that clears on the wrong number changes which later inserts wait, and it becomes visible at once on the fence outputs and the conflict counters. The bench compares every one of these outputs against a behavioural model on every cycle, so a divergence is reported in the cycle after the command that causes it.

// File: rtl/mdep_pkg.sv
// Shared command and kind encodings of the memory dependence scoreboard.
// Assumes one command per cycle on the shared command port.
package mdep_pkg;
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_INSERT   = 3'd1,
        OP_REGRDY   = 3'd2,
        OP_NSREL    = 3'd3,
        OP_COMPLETE = 3'd4,
        OP_RESCHED  = 3'd5,
        OP_REPLAY   = 3'd6,
        OP_SQUASH   = 3'd7
    } mdep_op_e;

    typedef enum logic [1:0] {
        K_LOAD  = 2'd0,
        K_STORE = 2'd1,
        K_FULLB = 2'd2,
        K_WRB   = 2'd3
    } mdep_kind_e;
endpackage

// File: rtl/mdep_first_one.sv
// Lowest-index priority picker.
// Reports whether any request bit is set, and the index of the lowest one.
module mdep_first_one #(
    parameter int N  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so that the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mdep_seq_cam.sv
// Parallel tag match of one sequence number against every slot.
// Assumes that at most one enabled slot carries a given number.
module mdep_seq_cam #(
    parameter int N     = 16,
    parameter int SEQ_W = 16,
    parameter int IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            en,
    input  logic [N-1:0][SEQ_W-1:0] tags,
    input  logic [SEQ_W-1:0]        key,
    output logic                    hit,
    output logic [IW-1:0]           hit_idx
);
    logic [N-1:0] match;

    // One comparator per slot.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = en[g] && (tags[g] == key);
    end

    mdep_first_one #(.N(N), .IW(IW)) u_pick (
        .req   (match),
        .found (hit),
        .idx   (hit_idx)
    );
endmodule

// File: rtl/mdep_fence_regs.sv
// Load and store fence flags with the sequence number of the barrier that set each one.
// Assumes a set and a clear never arrive in the same cycle.
module mdep_fence_regs #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_full,
    input  logic             set_write,
    input  logic [SEQ_W-1:0] set_seq,
    input  logic             clr_full,
    input  logic             clr_write,
    input  logic [SEQ_W-1:0] clr_seq,
    output logic             ld_on,
    output logic             st_on,
    output logic [SEQ_W-1:0] ld_seq,
    output logic [SEQ_W-1:0] st_seq
);
    // Load fence: set by a full barrier, cleared only by that same barrier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_on  <= 1'b0;
            ld_seq <= '0;
        end else if (set_full) begin
            ld_on  <= 1'b1;
            ld_seq <= set_seq;
        end else if (clr_full && ld_seq == clr_seq) begin
            ld_on  <= 1'b0;
        end
    end

    // Store fence: set by either barrier kind, cleared only on a number match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_on  <= 1'b0;
            st_seq <= '0;
        end else if (set_full || set_write) begin
            st_on  <= 1'b1;
            st_seq <= set_seq;
        end else if ((clr_full || clr_write) && st_seq == clr_seq) begin
            st_on  <= 1'b0;
        end
    end

    assert_full_sets_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_full |=> (ld_on && st_on && ld_seq == $past(set_seq) && st_seq == $past(set_seq)));

    assert_write_spares_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_write && !set_full) |=> (st_on && $stable(ld_on)));

    assert_mismatch_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_full || clr_write) && !set_full && !set_write && st_on && st_seq != clr_seq)
        |=> st_on);
endmodule

// File: rtl/mdep_scoreboard.sv
// Memory dependence wakeup scoreboard.
// Holds in-flight loads, stores and barriers. It links each waiting entry to the
// slot of its producing store or barrier, wakes dependents on completion, handles
// replay and per-thread squash, and presents released entries lowest slot first.
// Assumes unique, non-wrapping sequence numbers and one command per cycle.
module mdep_scoreboard
    import mdep_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int SEQ_W   = 16,
    parameter int TID_W   = 1,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd_op,
    input  logic [SEQ_W-1:0] cmd_seq,
    input  logic [TID_W-1:0] cmd_tid,
    input  logic [1:0]       cmd_kind,
    input  logic             cmd_regs_rdy,
    input  logic             cmd_nonspec,
    input  logic [SEQ_W-1:0] pred_seq,
    output logic             tbl_full,
    output logic             rdy_valid,
    input  logic             rdy_ready,
    output logic [SEQ_W-1:0] rdy_seq,
    output logic [TID_W-1:0] rdy_tid,
    output logic             ld_fence_on,
    output logic             st_fence_on,
    output logic [CNT_W-1:0] conflict_loads,
    output logic [CNT_W-1:0] conflict_stores
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // Slot state.
    logic [ENTRIES-1:0]            v_q, regs_q, mdep_q, ns_q, hp_q, pend_q, rs_q;
    logic [ENTRIES-1:0][SEQ_W-1:0] seq_q;
    logic [ENTRIES-1:0][TID_W-1:0] tid_q;
    logic [ENTRIES-1:0][1:0]       kind_q;
    logic [ENTRIES-1:0][IW-1:0]    pidx_q;
    logic [CNT_W-1:0]              cl_q, cs_q;

    mdep_op_e   op;
    mdep_kind_e kind_in;
    logic [ENTRIES-1:0] prod_cap;
    logic       free_found, pick_found, cmd_hit, prod_hit;
    logic [IW-1:0] free_idx, pick_idx, cmd_idx, prod_idx;
    logic       ins, spec_ins, nonspec_eff, prod_found, handshake, waker;
    logic [SEQ_W-1:0] ld_fseq, st_fseq, prod_seq;
    logic       set_full, set_write, clr_full, clr_write;

    // Command decode and producer selection.
    always_comb begin
        op          = mdep_op_e'(cmd_op);
        kind_in     = mdep_kind_e'(cmd_kind);
        ins         = (op == OP_INSERT) && !tbl_full;
        nonspec_eff = cmd_nonspec || cmd_kind[1];
        spec_ins    = ins && !nonspec_eff;
        if (kind_in == K_LOAD && ld_fence_on)
            prod_seq = ld_fseq;
        else if (kind_in == K_STORE && st_fence_on)
            prod_seq = st_fseq;
        else
            prod_seq = pred_seq;
        prod_found  = spec_ins && (prod_seq != '0) && prod_hit;
        handshake   = rdy_valid && rdy_ready;
        waker       = cmd_hit && (kind_q[cmd_idx] != K_LOAD);
        set_full    = ins && kind_in == K_FULLB;
        set_write   = ins && kind_in == K_WRB;
        clr_full    = (op == OP_COMPLETE) && cmd_hit && kind_q[cmd_idx] == K_FULLB;
        clr_write   = (op == OP_COMPLETE) && cmd_hit && kind_q[cmd_idx] == K_WRB;
    end

    // Only stores and barriers may act as producers.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cap
        assign prod_cap[g] = v_q[g] && (kind_q[g] != K_LOAD);
    end

    mdep_first_one #(.N(ENTRIES), .IW(IW)) u_free (
        .req (~v_q), .found (free_found), .idx (free_idx)
    );

    mdep_first_one #(.N(ENTRIES), .IW(IW)) u_out (
        .req (pend_q), .found (pick_found), .idx (pick_idx)
    );

    mdep_seq_cam #(.N(ENTRIES), .SEQ_W(SEQ_W), .IW(IW)) u_cmd_cam (
        .en (v_q), .tags (seq_q), .key (cmd_seq), .hit (cmd_hit), .hit_idx (cmd_idx)
    );

    mdep_seq_cam #(.N(ENTRIES), .SEQ_W(SEQ_W), .IW(IW)) u_prod_cam (
        .en (prod_cap), .tags (seq_q), .key (prod_seq), .hit (prod_hit), .hit_idx (prod_idx)
    );

    mdep_fence_regs #(.SEQ_W(SEQ_W)) u_fence (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_full  (set_full),
        .set_write (set_write),
        .set_seq   (cmd_seq),
        .clr_full  (clr_full),
        .clr_write (clr_write),
        .clr_seq   (cmd_seq),
        .ld_on     (ld_fence_on),
        .st_on     (st_fence_on),
        .ld_seq    (ld_fseq),
        .st_seq    (st_fseq)
    );

    // Per-slot update: output handshake first, then the command of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0; regs_q <= '0; mdep_q <= '0; ns_q <= '0;
            hp_q <= '0; pend_q <= '0; rs_q <= '0;
            seq_q <= '0; tid_q <= '0; kind_q <= '0; pidx_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (handshake && pick_idx == IW'(i))
                    pend_q[i] <= 1'b0;
                case (op)
                    OP_INSERT: begin
                        if (ins && free_found && free_idx == IW'(i)) begin
                            v_q[i]    <= 1'b1;
                            seq_q[i]  <= cmd_seq;
                            tid_q[i]  <= cmd_tid;
                            kind_q[i] <= cmd_kind;
                            ns_q[i]   <= nonspec_eff;
                            regs_q[i] <= cmd_regs_rdy;
                            mdep_q[i] <= !prod_found;
                            hp_q[i]   <= prod_found;
                            pidx_q[i] <= prod_idx;
                            pend_q[i] <= !prod_found && cmd_regs_rdy && !nonspec_eff;
                            rs_q[i]   <= 1'b0;
                        end
                    end
                    OP_REGRDY: begin
                        if (cmd_hit && cmd_idx == IW'(i)) begin
                            regs_q[i] <= 1'b1;
                            if (mdep_q[i] && !ns_q[i])
                                pend_q[i] <= 1'b1;
                        end
                    end
                    OP_NSREL: begin
                        if (cmd_hit && cmd_idx == IW'(i))
                            pend_q[i] <= 1'b1;
                    end
                    OP_COMPLETE: begin
                        if (cmd_hit && cmd_idx == IW'(i)) begin
                            v_q[i]    <= 1'b0;
                            pend_q[i] <= 1'b0;
                            rs_q[i]   <= 1'b0;
                        end else if (waker && v_q[i] && hp_q[i] && pidx_q[i] == cmd_idx) begin
                            hp_q[i]   <= 1'b0;
                            mdep_q[i] <= 1'b1;
                            if (regs_q[i] && !ns_q[i])
                                pend_q[i] <= 1'b1;
                        end
                    end
                    OP_RESCHED: begin
                        if (cmd_hit && cmd_idx == IW'(i))
                            rs_q[i] <= 1'b1;
                    end
                    OP_REPLAY: begin
                        if (rs_q[i]) begin
                            pend_q[i] <= 1'b1;
                            rs_q[i]   <= 1'b0;
                        end
                    end
                    OP_SQUASH: begin
                        if (v_q[i] && tid_q[i] == cmd_tid && seq_q[i] > cmd_seq) begin
                            v_q[i]    <= 1'b0;
                            pend_q[i] <= 1'b0;
                            rs_q[i]   <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Conflict counters, one per kind of waiting entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl_q <= '0;
            cs_q <= '0;
        end else if (prod_found) begin
            if (kind_in == K_LOAD)
                cl_q <= cl_q + 1'b1;
            else
                cs_q <= cs_q + 1'b1;
        end
    end

    assign tbl_full        = &v_q;
    assign rdy_valid       = pick_found;
    assign rdy_seq         = seq_q[pick_idx];
    assign rdy_tid         = tid_q[pick_idx];
    assign conflict_loads  = cl_q;
    assign conflict_stores = cs_q;

    // Assertion-only record of the last squash point.
    logic [SEQ_W-1:0]   sq_seq_q;
    logic [TID_W-1:0]   sq_tid_q;
    logic [ENTRIES-1:0] young_left;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_seq_q <= '0;
            sq_tid_q <= '0;
        end else if (op == OP_SQUASH) begin
            sq_seq_q <= cmd_seq;
            sq_tid_q <= cmd_tid;
        end
    end
    for (genvar g = 0; g < ENTRIES; g++) begin : g_young
        assign young_left[g] = (v_q[g] || pend_q[g] || rs_q[g]) &&
                               tid_q[g] == sq_tid_q && seq_q[g] > sq_seq_q;
    end

    assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INSERT && tbl_full) |=> ($countones(v_q) == $countones($past(v_q))));

    assert_squash_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SQUASH) |=> (young_left == '0));

    assert_replay_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_REPLAY) |=> (rs_q == '0));

    assert_hold_output_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_valid && !rdy_ready && op != OP_COMPLETE && op != OP_SQUASH) |=> rdy_valid);
endmodule

// File: tb/mdep_scoreboard_tb_top.sv
`timescale 1ns/1ps
module mdep_scoreboard_tb_top;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [15:0] cmd_seq = '0;
    logic [0:0]  cmd_tid = '0;
    logic [1:0]  cmd_kind = '0;
    logic        cmd_regs_rdy = 1'b0;
    logic        cmd_nonspec = 1'b0;
    logic [15:0] pred_seq = '0;
    logic        rdy_ready = 1'b1;
    logic        tbl_full, rdy_valid, ld_fence_on, st_fence_on;
    logic [15:0] rdy_seq;
    logic [0:0]  rdy_tid;
    logic [7:0]  conflict_loads, conflict_stores;

    always #2 clk = ~clk;

    mdep_scoreboard dut_i (
        .clk (clk), .rst_n (rst_n), .cmd_op (cmd_op), .cmd_seq (cmd_seq),
        .cmd_tid (cmd_tid), .cmd_kind (cmd_kind), .cmd_regs_rdy (cmd_regs_rdy),
        .cmd_nonspec (cmd_nonspec), .pred_seq (pred_seq), .tbl_full (tbl_full),
        .rdy_valid (rdy_valid), .rdy_ready (rdy_ready), .rdy_seq (rdy_seq),
        .rdy_tid (rdy_tid), .ld_fence_on (ld_fence_on), .st_fence_on (st_fence_on),
        .conflict_loads (conflict_loads), .conflict_stores (conflict_stores)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    armed = 1'b0;
    bit    done = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model.
    bit m_v[N], m_rg[N], m_md[N], m_ns[N], m_hp[N], m_pd[N], m_rs[N];
    int m_seq[N], m_tid[N], m_kind[N], m_pidx[N];
    bit m_ldon, m_ston;
    int m_ldseq, m_stseq, m_cl, m_cs;

    function automatic int lowest_pend();
        for (int i = 0; i < N; i++) if (m_pd[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_v[i] = 0; m_pd[i] = 0; m_rs[i] = 0; m_hp[i] = 0;
                m_seq[i] = 0; m_tid[i] = 0;
            end
            m_ldon = 0; m_ston = 0; m_ldseq = 0; m_stseq = 0; m_cl = 0; m_cs = 0;
        end else begin
            int p, hit, op, sq;
            p = lowest_pend();
            if (rdy_ready && p >= 0) m_pd[p] = 0;
            op = int'(cmd_op); sq = int'(cmd_seq);
            hit = -1;
            for (int i = 0; i < N; i++) if (hit < 0 && m_v[i] && m_seq[i] == sq) hit = i;
            case (op)
                1: begin
                    int f, k, ps, pi;
                    bit ns;
                    f = -1;
                    for (int i = 0; i < N; i++) if (f < 0 && !m_v[i]) f = i;
                    k = int'(cmd_kind);
                    ns = cmd_nonspec || k >= 2;
                    pi = -1;
                    if (f >= 0) begin
                        if (!ns) begin
                            ps = (k == 0 && m_ldon) ? m_ldseq :
                                 (k == 1 && m_ston) ? m_stseq : int'(pred_seq);
                            if (ps != 0)
                                for (int i = 0; i < N; i++)
                                    if (pi < 0 && m_v[i] && m_kind[i] != 0 && m_seq[i] == ps) pi = i;
                        end
                        if (k == 2) begin m_ldon = 1; m_ldseq = sq; end
                        if (k >= 2) begin m_ston = 1; m_stseq = sq; end
                        m_v[f] = 1; m_seq[f] = sq; m_tid[f] = int'(cmd_tid); m_kind[f] = k;
                        m_ns[f] = ns; m_rg[f] = cmd_regs_rdy; m_md[f] = (pi < 0);
                        m_hp[f] = (pi >= 0); m_pidx[f] = pi; m_rs[f] = 0;
                        m_pd[f] = (pi < 0) && cmd_regs_rdy && !ns;
                        if (pi >= 0) begin
                            if (k == 0) m_cl++; else m_cs++;
                        end
                    end
                end
                2: if (hit >= 0) begin
                    m_rg[hit] = 1;
                    if (m_md[hit] && !m_ns[hit]) m_pd[hit] = 1;
                end
                3: if (hit >= 0) m_pd[hit] = 1;
                4: if (hit >= 0) begin
                    if (m_kind[hit] != 0)
                        for (int j = 0; j < N; j++)
                            if (j != hit && m_v[j] && m_hp[j] && m_pidx[j] == hit) begin
                                m_hp[j] = 0; m_md[j] = 1;
                                if (m_rg[j] && !m_ns[j]) m_pd[j] = 1;
                            end
                    if (m_kind[hit] == 2 && m_ldseq == sq) m_ldon = 0;
                    if (m_kind[hit] >= 2 && m_stseq == sq) m_ston = 0;
                    m_v[hit] = 0; m_pd[hit] = 0; m_rs[hit] = 0;
                end
                5: if (hit >= 0) m_rs[hit] = 1;
                6: for (int i = 0; i < N; i++) if (m_rs[i]) begin m_pd[i] = 1; m_rs[i] = 0; end
                7: for (int i = 0; i < N; i++)
                    if (m_v[i] && m_tid[i] == int'(cmd_tid) && m_seq[i] > sq) begin
                        m_v[i] = 0; m_pd[i] = 0; m_rs[i] = 0;
                    end
                default: ;
            endcase
        end
    end

    // Compare every output against the model on every falling edge.
    always @(negedge clk) begin
        if (armed && rst_n) begin
            int p;
            bit full;
            p = lowest_pend();
            full = 1;
            for (int i = 0; i < N; i++) if (!m_v[i]) full = 0;
            chk({cur_req, " R13 rdy_valid"}, int'(rdy_valid), int'(p >= 0));
            if (p >= 0) begin
                chk({cur_req, " R13 rdy_seq"}, int'(rdy_seq), m_seq[p]);
                chk({cur_req, " R13 rdy_tid"}, int'(rdy_tid), m_tid[p]);
            end
            chk({cur_req, " R2 tbl_full"}, int'(tbl_full), int'(full));
            chk({cur_req, " R3 ld_fence_on"}, int'(ld_fence_on), int'(m_ldon));
            chk({cur_req, " R3 st_fence_on"}, int'(st_fence_on), int'(m_ston));
            chk({cur_req, " R6 conflict_loads"}, int'(conflict_loads), m_cl % 256);
            chk({cur_req, " R6 conflict_stores"}, int'(conflict_stores), m_cs % 256);
        end
    end

    task automatic issue(input int op, input int seq, input int tid, input int kind,
                         input bit rg, input bit ns, input int pred);
        cmd_op = op[2:0]; cmd_seq = seq[15:0]; cmd_tid = tid[0:0]; cmd_kind = kind[1:0];
        cmd_regs_rdy = rg; cmd_nonspec = ns; pred_seq = pred[15:0];
        @(posedge clk);
        @(negedge clk);
        cmd_op = 3'd0; cmd_regs_rdy = 1'b0; cmd_nonspec = 1'b0; pred_seq = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        cur_req = "R1";
        chk("R1 rdy_valid after reset", int'(rdy_valid), 0);
        chk("R1 tbl_full after reset", int'(tbl_full), 0);
        chk("R1 fences after reset", int'(ld_fence_on) + int'(st_fence_on), 0);
        chk("R1 counters after reset", int'(conflict_loads) + int'(conflict_stores), 0);
        armed = 1'b1;

        cur_req = "R5";
        issue(1, 10, 0, 0, 1, 0, 0);
        chk("R5 released by insert", int'(rdy_valid), 1);
        chk("R5 released seq", int'(rdy_seq), 10);
        idle(1);

        cur_req = "R7";
        issue(1, 11, 0, 1, 0, 0, 0);
        idle(1);
        issue(2, 11, 0, 0, 0, 0, 0);
        idle(1);

        cur_req = "R6";
        issue(1, 12, 0, 0, 1, 0, 11);
        issue(1, 13, 0, 0, 0, 0, 11);
        chk("R6 dependent load counted", int'(conflict_loads), 2);
        cur_req = "R8";
        issue(4, 11, 0, 0, 0, 0, 0);
        idle(1);
        cur_req = "R7";
        issue(2, 13, 0, 0, 0, 0, 0);
        idle(1);
        cur_req = "R8";
        issue(1, 15, 0, 0, 0, 0, 12);
        issue(4, 12, 0, 0, 0, 0, 0);
        issue(2, 15, 0, 0, 0, 0, 0);
        idle(1);

        cur_req = "R5";
        issue(1, 14, 0, 0, 1, 0, 99);
        idle(1);

        cur_req = "R3";
        issue(1, 20, 0, 2, 0, 0, 0);
        chk("R3 full barrier sets load fence", int'(ld_fence_on), 1);
        cur_req = "R4";
        issue(1, 21, 0, 0, 1, 0, 0);
        issue(1, 22, 0, 1, 1, 0, 0);
        cur_req = "R3";
        issue(1, 23, 0, 3, 0, 0, 0);
        cur_req = "R9";
        issue(4, 20, 0, 0, 0, 0, 0);
        chk("R9 load fence cleared on match", int'(ld_fence_on), 0);
        chk("R9 store fence kept on mismatch", int'(st_fence_on), 1);
        idle(2);
        cur_req = "R4";
        issue(1, 24, 0, 1, 1, 0, 0);
        cur_req = "R11";
        issue(3, 23, 0, 0, 0, 0, 0);
        idle(1);
        cur_req = "R9";
        issue(4, 23, 0, 0, 0, 0, 0);
        idle(1);

        cur_req = "R11";
        issue(1, 30, 0, 0, 1, 1, 0);
        issue(2, 30, 0, 0, 0, 0, 0);
        chk("R11 register event does not release", int'(rdy_valid), 0);
        issue(3, 30, 0, 0, 0, 0, 0);
        idle(1);

        cur_req = "R12";
        issue(5, 30, 0, 0, 0, 0, 0);
        issue(5, 14, 0, 0, 0, 0, 0);
        rdy_ready = 1'b0;
        issue(6, 0, 0, 0, 0, 0, 0);
        cur_req = "R13";
        idle(3);
        chk("R13 held while not accepted", int'(rdy_valid), 1);
        rdy_ready = 1'b1;
        idle(3);

        cur_req = "R10";
        issue(1, 40, 1, 0, 0, 0, 0);
        issue(1, 41, 1, 0, 0, 0, 0);
        issue(1, 42, 1, 0, 0, 0, 0);
        issue(1, 43, 0, 0, 0, 0, 0);
        issue(5, 42, 1, 0, 0, 0, 0);
        rdy_ready = 1'b0;
        issue(3, 41, 1, 0, 0, 0, 0);
        issue(7, 40, 1, 0, 0, 0, 0);
        chk("R10 squashed release withdrawn", int'(rdy_valid), 0);
        rdy_ready = 1'b1;
        issue(2, 41, 1, 0, 0, 0, 0);
        issue(6, 0, 0, 0, 0, 0, 0);
        chk("R10 squashed replay mark gone", int'(rdy_valid), 0);
        issue(2, 40, 1, 0, 0, 0, 0);
        idle(1);
        issue(2, 43, 0, 0, 0, 0, 0);
        idle(1);

        cur_req = "R1";
        armed = 1'b0;
        do_reset();
        armed = 1'b1;
        cur_req = "R2";
        for (int s = 100; s < 116; s++) issue(1, s, 0, 0, 0, 0, 0);
        chk("R2 full after sixteen inserts", int'(tbl_full), 1);
        issue(1, 116, 0, 0, 1, 0, 0);
        issue(2, 116, 0, 0, 0, 0, 0);
        chk("R2 dropped insert never appears", int'(rdy_valid), 0);
        issue(4, 103, 0, 0, 0, 0, 0);
        issue(1, 120, 0, 0, 1, 0, 0);
        chk("R2 reuses freed slot", int'(rdy_seq), 120);
        idle(2);

        finish_run();
    end
endmodule